// File: doc/BRIEF.md
# Response Ring Writer with Interrupt and Overrun Status

This block takes responses arriving from several serial codec input lanes, holds them in a small staging FIFO and drains them one at a time as 64-bit entries into a circular response buffer of 256 entries, using a request/acknowledge write interface that carries the ring index and the entry. Each slot strobe offers up to one response per lane. Lanes that carry a response are queued in lane order. A slot in which no lane carries a response is an empty slot.

Software sees a small register window. It holds a status byte whose bits are cleared by writing 1, interrupt enables, a response-count threshold, a read-only ring size descriptor and the ring write pointer, which software can also reset. The response interrupt status sets when the programmed number of entries has been written to the ring, or when an empty slot occurs, whichever comes first. The overrun status sets when responses arrive that the full FIFO cannot take; those responses are discarded. The interrupt output is a level derived from the status bits and their enables.

Top module: `resp_ring_ctrl`

## Requirements
- R1: After synchronous reset, wr_req and irq are 0, the status and threshold registers read 0, the enables are off and the write pointer reads 0.
- R2: The status register (address 0) has response-interrupt status in bit 0 and overrun status in bit 2. Bits 7:3 and bit 1 read 0. Writing 1 to bit 0 or bit 2 clears that bit, and writing 0 leaves it unchanged. reg_rdata shows the register addressed in the previous cycle.
- R3: Address 3 always reads 8'h42 (capability 4'b0100 in bits 7:4, size code 2'b10 in bits 1:0). Writes to it have no effect.
- R4: On a slot strobe, every lane with lane_valid set yields one ring entry, in ascending lane order. The entry carries the lane's 32-bit data in bits 31:0, the lane index in bits 39:32 and zeros above.
- R5: Once wr_req is raised it stays high, with wr_data and wr_addr unchanged, until a cycle with wr_ack high completes the write.
- R6: wr_addr is the ring write pointer (readable at address 4). It advances by one on each completed write and wraps from 255 to 0. Writing 1 to bit 0 of address 4 resets it to 0.
- R7: Response-interrupt status sets when the number of completed writes since it was last set reaches the threshold at address 2. A threshold of 0 means 256.
- R8: A slot strobe with no lane valid sets response-interrupt status and restarts the completed-write count.
- R9: The staging FIFO holds 8 responses. On a slot strobe, valid lanes are accepted in lane order while space remains, and the rest are dropped. Any drop sets overrun status at that clock edge. No drop occurs while space suffices.
- R10: Both status bits set regardless of the enables. The enables are bit 0 (response) and bit 2 (overrun) of address 1. irq is high exactly while some status bit and its enable are both 1.
- R11: When a hardware set and a software write-1 clear hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_stb | input | 1 | Response slot strobe |
| lane_valid | input | LANES | Per-lane response present in this slot |
| lane_data | input | LANES*DATA_W | Per-lane response words, lane 0 in the low bits |
| reg_wen | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, one cycle after the address |
| wr_req | output | 1 | Ring write request |
| wr_addr | output | RING_AW | Ring entry index |
| wr_data | output | 64 | Ring entry |
| wr_ack | input | 1 | Ring write accepted this cycle |
| irq | output | 1 | Level interrupt |

## Verification
The response-interrupt status can be set by hardware (an empty slot) in the same cycle that software writes 1 to clear it. The bench forces this by raising an empty slot strobe and a status write of 8'h01 on the same clock edge, and it passes only if the bit reads back as 1; a separate clear with no event must still read 0. Overrun detection and entry acceptance also meet in one slot when the FIFO has room for only one of three lanes. There the bench expects lane 0 to reach the ring and the other two lanes to be missing from the drained sequence.

// File: rtl/resp_ring_pkg.sv
package resp_ring_pkg;
  localparam int ENTRY_W = 64;
  typedef logic [ENTRY_W-1:0] entry_t;

  localparam logic [2:0] ADR_STAT = 3'd0;
  localparam logic [2:0] ADR_CTRL = 3'd1;
  localparam logic [2:0] ADR_THR  = 3'd2;
  localparam logic [2:0] ADR_SIZE = 3'd3;
  localparam logic [2:0] ADR_PTR  = 3'd4;

  localparam int BIT_RESP = 0;
  localparam int BIT_OVR  = 2;

  localparam logic [7:0] SIZE_DESC = 8'h42;
endpackage

// File: rtl/resp_fifo.sv
module resp_fifo
  import resp_ring_pkg::*;
#(
  parameter int LANES  = 3,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    push_en,
  input  logic [LANES-1:0]        lane_valid,
  input  logic [LANES*DATA_W-1:0] lane_data,
  input  logic                    pop,
  output entry_t                  head,
  output logic                    empty,
  output logic                    full,
  output logic [CW-1:0]           level,
  output logic                    dropped
);
  localparam int TW   = $clog2(DEPTH + LANES + 1);
  localparam int PADW = ENTRY_W - DATA_W - 8;

  entry_t         mem [DEPTH];
  logic [AW-1:0]  wp, rp;
  logic [TW-1:0]  space, taken;
  logic [LANES-1:0] acc;
  logic [AW-1:0]  off [LANES];

  // Lanes take free places in ascending order; the surplus is dropped.
  always_comb begin
    space   = TW'(DEPTH) - TW'(level);
    taken   = '0;
    dropped = 1'b0;
    for (int k = 0; k < LANES; k++) begin
      acc[k] = 1'b0;
      off[k] = AW'(taken);
      if (push_en && lane_valid[k]) begin
        if (taken < space) begin
          acc[k] = 1'b1;
          taken  = taken + TW'(1);
        end else begin
          dropped = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (acc[k]) begin
        mem[wp + off[k]] <= {{PADW{1'b0}}, 8'(k), lane_data[k*DATA_W +: DATA_W]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      wp    <= wp + AW'(taken);
      if (pop) rp <= rp + AW'(1);
      level <= CW'(TW'(level) + taken - TW'(pop));
    end
  end

  assign head  = mem[rp];
  assign empty = (level == '0);
  assign full  = (level == CW'(DEPTH));
endmodule

// File: rtl/resp_drain.sv
module resp_drain
  import resp_ring_pkg::*;
#(
  parameter int RING_AW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fifo_empty,
  input  entry_t             head,
  input  logic               ack,
  input  logic               ptr_clr,
  output logic               pop,
  output logic               req,
  output entry_t             data,
  output logic [RING_AW-1:0] ptr,
  output logic               done
);
  assign done = req && ack;
  assign pop  = !fifo_empty && (!req || ack);

  always_ff @(posedge clk) begin
    if (rst) begin
      req  <= 1'b0;
      data <= '0;
    end else if (pop) begin
      req  <= 1'b1;
      data <= head;
    end else if (done) begin
      req  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ptr_clr) ptr <= '0;
    else if (done)      ptr <= ptr + RING_AW'(1);
  end
endmodule

// File: rtl/resp_status.sv
module resp_status
  import resp_ring_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       done,
  input  logic       empty_slot,
  input  logic       drop,
  input  logic [7:0] thr,
  input  logic       clr_resp,
  input  logic       clr_ovr,
  output logic [7:0] stat
);
  logic [8:0] cnt, limit;
  logic       resp_q, ovr_q, hit, set_resp;

  assign limit    = (thr == 8'd0) ? 9'd256 : {1'b0, thr};
  assign hit      = done && ((cnt + 9'd1) == limit);
  assign set_resp = hit || empty_slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      resp_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (set_resp)  cnt <= '0;
      else if (done) cnt <= cnt + 9'd1;
      resp_q <= set_resp || (resp_q && !clr_resp);
      ovr_q  <= drop || (ovr_q && !clr_ovr);
    end
  end

  always_comb begin
    stat           = '0;
    stat[BIT_RESP] = resp_q;
    stat[BIT_OVR]  = ovr_q;
  end
endmodule

// File: rtl/resp_ring_ctrl.sv
module resp_ring_ctrl
  import resp_ring_pkg::*;
#(
  parameter int LANES      = 3,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 8,
  parameter int RING_AW    = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    slot_stb,
  input  logic [LANES-1:0]        lane_valid,
  input  logic [LANES*DATA_W-1:0] lane_data,
  input  logic                    reg_wen,
  input  logic [2:0]              reg_addr,
  input  logic [7:0]              reg_wdata,
  output logic [7:0]              reg_rdata,
  output logic                    wr_req,
  output logic [RING_AW-1:0]      wr_addr,
  output logic [63:0]             wr_data,
  input  logic                    wr_ack,
  output logic                    irq
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  entry_t        head;
  logic          fifo_empty, fifo_full, drop, pop, done, ptr_clr, empty_slot;
  logic [CW-1:0] fifo_level;
  logic [7:0]    stat_w, thr_q;
  logic          en_resp, en_ovr, wr_stat;

  assign empty_slot = slot_stb && (lane_valid == '0);
  assign wr_stat    = reg_wen && (reg_addr == ADR_STAT);
  assign ptr_clr    = reg_wen && (reg_addr == ADR_PTR) && reg_wdata[0];

  resp_fifo #(.LANES(LANES), .DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push_en(slot_stb), .lane_valid(lane_valid),
    .lane_data(lane_data), .pop(pop), .head(head), .empty(fifo_empty),
    .full(fifo_full), .level(fifo_level), .dropped(drop)
  );

  resp_drain #(.RING_AW(RING_AW)) u_drain (
    .clk(clk), .rst(rst), .fifo_empty(fifo_empty), .head(head), .ack(wr_ack),
    .ptr_clr(ptr_clr), .pop(pop), .req(wr_req), .data(wr_data),
    .ptr(wr_addr), .done(done)
  );

  resp_status u_stat (
    .clk(clk), .rst(rst), .done(done), .empty_slot(empty_slot), .drop(drop),
    .thr(thr_q), .clr_resp(wr_stat && reg_wdata[BIT_RESP]),
    .clr_ovr(wr_stat && reg_wdata[BIT_OVR]), .stat(stat_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_resp <= 1'b0;
      en_ovr  <= 1'b0;
      thr_q   <= '0;
    end else if (reg_wen) begin
      if (reg_addr == ADR_CTRL) begin
        en_resp <= reg_wdata[BIT_RESP];
        en_ovr  <= reg_wdata[BIT_OVR];
      end
      if (reg_addr == ADR_THR) thr_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        ADR_STAT: reg_rdata <= stat_w;
        ADR_CTRL: begin
          reg_rdata           <= '0;
          reg_rdata[BIT_RESP] <= en_resp;
          reg_rdata[BIT_OVR]  <= en_ovr;
        end
        ADR_THR:  reg_rdata <= thr_q;
        ADR_SIZE: reg_rdata <= SIZE_DESC;
        ADR_PTR:  reg_rdata <= 8'(wr_addr);
        default:  reg_rdata <= '0;
      endcase
    end
  end

  assign irq = (stat_w[BIT_RESP] && en_resp) || (stat_w[BIT_OVR] && en_ovr);
endmodule

// File: rtl/resp_ring_chk.sv
module resp_ring_chk #(
  parameter int LANES      = 3,
  parameter int FIFO_DEPTH = 8,
  parameter int RING_AW    = 8,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic               slot_stb,
  input logic [LANES-1:0]   lane_valid,
  input logic [2:0]         reg_addr,
  input logic [7:0]         reg_rdata,
  input logic               wr_req,
  input logic               wr_ack,
  input logic [RING_AW-1:0] wr_addr,
  input logic [63:0]        wr_data,
  input logic               ptr_clr,
  input logic               irq,
  input logic [7:0]         stat_w,
  input logic               fifo_full,
  input logic [CW-1:0]      fifo_level
);
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_level <= CW'(FIFO_DEPTH));

  // R9
  ovr_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_stb && fifo_full && (lane_valid != '0)) |=> stat_w[2]);

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_ack && !ptr_clr) |=> (wr_req && $stable(wr_data) && $stable(wr_addr)));

  // R6
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_req && wr_ack && !ptr_clr && (wr_addr == '1)) |=> (wr_addr == '0));

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_stb && (lane_valid == '0)) |=> stat_w[0]);

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (stat_w[0] || stat_w[2]));

  // R3
  size_read_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == 3'd3) |=> (reg_rdata == 8'h42));
endmodule

bind resp_ring_ctrl resp_ring_chk #(
  .LANES(LANES), .FIFO_DEPTH(FIFO_DEPTH), .RING_AW(RING_AW)
) chk_i (
  .clk(clk), .rst(rst), .slot_stb(slot_stb), .lane_valid(lane_valid),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .wr_req(wr_req),
  .wr_ack(wr_ack), .wr_addr(wr_addr), .wr_data(wr_data), .ptr_clr(ptr_clr),
  .irq(irq), .stat_w(stat_w), .fifo_full(fifo_full), .fifo_level(fifo_level)
);

// File: tb/resp_ring_ctrl_tb.sv
`timescale 1ns/1ps
module resp_ring_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slot_stb = 1'b0;
  logic [2:0]  lane_valid = '0;
  logic [95:0] lane_data = '0;
  logic        reg_wen = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        wr_req;
  logic [7:0]  wr_addr;
  logic [63:0] wr_data;
  logic        wr_ack = 1'b0;
  logic        irq;

  int total = 0, bad = 0;
  bit ack_rand = 0, ack_hold = 0, finished = 0;
  logic [63:0] expq[$];
  logic [7:0]  exp_addr = '0;
  int          writes = 0;
  bit          held_prev = 0;
  logic [63:0] held_data;

  always #2.5 clk = ~clk;

  resp_ring_ctrl dut_i (
    .clk(clk), .rst(rst), .slot_stb(slot_stb), .lane_valid(lane_valid),
    .lane_data(lane_data), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wr_req(wr_req),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack), .irq(irq)
  );

  function automatic logic [63:0] mk_entry(int lane, logic [31:0] d);
    return {24'h0, 8'(lane), d};
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    wr_ack = ack_rand ? ($urandom_range(3, 0) != 0) : ack_hold;
  end

  // Ring write monitor: order, content, address, hold
  always @(negedge clk) begin
    if (!rst) begin
      if (held_prev)
        chk(wr_req && wr_data == held_data, "R5 request held", wr_data, held_data);
      held_prev = wr_req && !wr_ack;
      held_data = wr_data;
      if (wr_req && wr_ack) begin
        if (expq.size() == 0) begin
          chk(0, "R4 unexpected entry", wr_data, 64'h0);
        end else begin
          logic [63:0] e;
          e = expq.pop_front();
          chk(wr_data == e, "R4 entry content/order", wr_data, e);
        end
        chk(wr_addr == exp_addr, "R6 ring index", 64'(wr_addr), 64'(exp_addr));
        exp_addr = exp_addr + 8'd1;
        writes++;
      end
    end
  end

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic reg_write(logic [2:0] a, logic [7:0] d);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_wen = 1'b0;
  endtask

  task automatic reg_read(logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    tick(1);
    d = reg_rdata;
  endtask

  task automatic send_slot(logic [2:0] v, logic [31:0] d0, logic [31:0] d1,
                           logic [31:0] d2, int fit);
    int n = 0;
    slot_stb = 1'b1; lane_valid = v; lane_data = {d2, d1, d0};
    for (int k = 0; k < 3; k++) begin
      if (v[k]) begin
        if (n < fit) expq.push_back(mk_entry(k, lane_data[k*32 +: 32]));
        n++;
      end
    end
    tick(1);
    slot_stb = 1'b0; lane_valid = '0;
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #750000;
    chk(0, "watchdog", 0, 0);
    finish_up();
  end

  initial begin
    logic [7:0] rd;
    void'($urandom(32'h5eed));
    tick(4);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    chk(!wr_req, "R1 wr_req", 64'(wr_req), 0);
    chk(!irq, "R1 irq", 64'(irq), 0);
    reg_read(3'd0, rd); chk(rd == 8'h00, "R1 status", rd, 0);
    reg_read(3'd4, rd); chk(rd == 8'h00, "R1 pointer", rd, 0);
    reg_read(3'd2, rd); chk(rd == 8'h00, "R1 threshold", rd, 0);
    reg_read(3'd1, rd); chk(rd == 8'h00, "R1 enables", rd, 0);

    // R3 size descriptor, read-only
    reg_read(3'd3, rd); chk(rd == 8'h42, "R3 size", rd, 8'h42);
    reg_write(3'd3, 8'hFF);
    reg_read(3'd3, rd); chk(rd == 8'h42, "R3 size after write", rd, 8'h42);

    // R4 lane order with a gap
    ack_hold = 1;
    send_slot(3'b101, 32'hA0A0_0001, 32'hBBBB_0002, 32'hC0C0_0003, 3);
    tick(6);
    chk(writes == 2 && expq.size() == 0, "R4 two entries", 64'(writes), 2);

    // R8 empty slot, R10 gating, R2 clear
    send_slot(3'b000, 0, 0, 0, 0);
    reg_read(3'd0, rd); chk(rd == 8'h01, "R8 empty slot sets", rd, 8'h01);
    chk(!irq, "R10 irq masked", 64'(irq), 0);
    reg_write(3'd1, 8'h01);
    chk(irq, "R10 irq enabled", 64'(irq), 1);
    reg_write(3'd0, 8'h04);
    reg_read(3'd0, rd); chk(rd == 8'h01, "R2 write-1 other bit", rd, 8'h01);
    reg_write(3'd0, 8'h01);
    chk(!irq, "R10 irq after clear", 64'(irq), 0);
    reg_read(3'd0, rd); chk(rd == 8'h00, "R2 cleared", rd, 8'h00);

    // R7 threshold of 5
    reg_write(3'd2, 8'd5);
    send_slot(3'b111, 32'h11, 32'h12, 32'h13, 3);
    tick(6);
    reg_read(3'd0, rd); chk(rd == 8'h00, "R7 below threshold", rd, 0);
    send_slot(3'b011, 32'h21, 32'h22, 32'h23, 3);
    tick(6);
    reg_read(3'd0, rd); chk(rd == 8'h01, "R7 threshold reached", rd, 8'h01);
    chk(irq, "R10 irq on threshold", 64'(irq), 1);

    // R7 threshold 0 means 256; R6 wrap checked by monitor
    send_slot(3'b000, 0, 0, 0, 0);
    reg_write(3'd0, 8'h01);
    reg_write(3'd2, 8'd0);
    for (int i = 0; i < 85; i++) begin
      send_slot(3'b111, $urandom, $urandom, $urandom, 3);
      tick(2);
    end
    tick(8);
    reg_read(3'd0, rd); chk(rd == 8'h00, "R7 255 of 256", rd, 0);
    send_slot(3'b010, 0, 32'h5555, 0, 3);
    tick(6);
    reg_read(3'd0, rd); chk(rd == 8'h01, "R7 256 writes", rd, 8'h01);
    reg_read(3'd4, rd); chk(rd == exp_addr, "R6 pointer after wrap", rd, exp_addr);

    // R11 set and clear in the same cycle
    reg_write(3'd0, 8'h01);
    slot_stb = 1'b1; lane_valid = '0;
    reg_wen = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h01;
    tick(1);
    slot_stb = 1'b0; reg_wen = 1'b0;
    reg_read(3'd0, rd); chk(rd == 8'h01, "R11 set wins", rd, 8'h01);
    reg_write(3'd0, 8'h01);
    reg_read(3'd0, rd); chk(rd == 8'h00, "R11 plain clear", rd, 0);

    // R9 overrun with partial acceptance
    reg_write(3'd1, 8'h00);
    ack_hold = 0;
    tick(2);
    send_slot(3'b111, 32'h31, 32'h32, 32'h33, 3); tick(3);
    send_slot(3'b111, 32'h41, 32'h42, 32'h43, 3); tick(3);
    send_slot(3'b011, 32'h51, 32'h52, 32'h53, 3); tick(3);
    reg_read(3'd0, rd); chk(rd == 8'h00, "R9 no drop with room", rd, 0);
    send_slot(3'b111, 32'h61, 32'h62, 32'h63, 1); tick(3);
    reg_read(3'd0, rd); chk(rd == 8'h04, "R9 overrun flagged", rd, 8'h04);
    chk(!irq, "R10 overrun masked", 64'(irq), 0);
    reg_write(3'd1, 8'h04);
    chk(irq, "R10 overrun irq", 64'(irq), 1);
    ack_hold = 1;
    tick(20);
    chk(expq.size() == 0, "R9 survivors drained", 64'(expq.size()), 0);
    reg_write(3'd0, 8'h04);
    chk(!irq, "R2 overrun cleared", 64'(irq), 0);

    // R6 pointer reset
    reg_write(3'd4, 8'h01);
    exp_addr = '0;
    reg_read(3'd4, rd); chk(rd == 8'h00, "R6 pointer reset", rd, 0);
    send_slot(3'b100, 0, 0, 32'h7777, 3);
    tick(5);

    // Random phase: R4 R5 under random acknowledge
    reg_write(3'd1, 8'h00);
    ack_rand = 1;
    for (int i = 0; i < 200; i++) begin
      while (expq.size() > 5) tick(1);
      send_slot(3'($urandom_range(7, 1)), $urandom, $urandom, $urandom, 3);
      tick($urandom_range(2, 0));
    end
    for (int i = 0; i < 200 && expq.size() != 0; i++) tick(1);
    tick(4);
    chk(expq.size() == 0, "R4 random drained", 64'(expq.size()), 0);
    reg_read(3'd0, rd); chk(rd[2] == 1'b0, "R9 no false overrun", rd, 0);
    finish_up();
  end
endmodule